// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block is a 64-bit event counter, used as a machine cycle counter or a retired-instruction counter. It comes with its own configuration register. That register holds one inhibit flag for each execution mode: machine, supervisor, user, virtual supervisor and virtual user. Each cycle the surrounding core may present a step together with an increment amount. The counter adds that amount only if the inhibit flag of the mode that ran the step is clear.

The mode seen by the gate is the one the core presented at the previous clock edge. A mode change presented in the same cycle as a step is therefore charged to the mode that was in effect before the change.

Software reaches both registers through a simple CSR port: write enable, register select, half select and write data. The read data is combinational. With a 32-bit register width, each 64-bit register is reached as two halves. A software write to the counter overrides any increment in that cycle. A configuration write never affects the increment in its own cycle.

The filtering can be removed at build time. The configuration register then has no writable bits and the counter is never inhibited.

Top module: `priv_filter_counter`

## Requirements
- R1: After a synchronous active-low reset, the counter and the configuration register are both zero, so every mode is counted. The mode in effect is machine, non-virtual.
- R2: Only configuration bits 62, 61, 60, 59 and 58 are writable. All other configuration bits read as zero. With a 32-bit width these are bits 30..26 of the high half, and the low half always reads zero.
- R3: In machine mode (priv 3, or the reserved value 2), the step is gated by configuration bit 62. The virtual flag is ignored.
- R4: In supervisor mode (priv 1), the step is gated by bit 61 when non-virtual and by bit 59 when virtual.
- R5: In user mode (priv 0), the step is gated by bit 60 when non-virtual and by bit 58 when virtual.
- R6: When step_i is high and the selected inhibit bit is zero, the counter rises by inc_i one cycle later. Otherwise it holds.
- R7: The mode used for gating is the priv_i/virt_i value captured at the previous clock edge. A change presented with a step does not affect that step.
- R8: A configuration write in the same cycle as a step does not affect that step. The new value gates steps from the next cycle on.
- R9: A counter write takes precedence over a same-cycle step. The written half holds the written value exactly.
- R10: With a 32-bit width, csr_hi_i selects bits 63:32 and otherwise bits 31:0. Writing one half leaves the other half unchanged. Increments carry across bit 32.
- R11: When built with filtering disabled, the configuration register reads zero after any write and every step is counted.
- R12: csr_rdata_o returns the register selected by csr_sel_i (0 counter, 1 configuration) and the half selected by csr_hi_i, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | An event step occurs this cycle |
| inc_i | input | INC_W | Amount to add for this step |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine, 2 treated as machine |
| virt_i | input | 1 | Virtualization flag |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 1 | 0 selects the counter, 1 the configuration register |
| csr_hi_i | input | 1 | High-half select (32-bit width only) |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data of the selected register and half |
| count_o | output | 64 | Counter value |
| cfg_o | output | 64 | Configuration value |

## Verification
A step and a software write can land in the same cycle. The bench provokes this in three ways:
- a step together with a configuration write that sets the inhibit flag of the current mode, and again with one that clears it;
- a step together with a counter write;
- a step together with a change on priv_i.

In each case the bench checks the counter one cycle later against the rule for that collision: the old configuration gates, the written value is kept exactly, and the earlier mode is charged. It then checks the next step to confirm that the new setting has taken effect.

// File: rtl/pfc_pkg.sv
// Shared types and constants for the privilege-filtered event counter.
// Assumes a 64-bit configuration value with inhibit flags in bits 62..58.
package pfc_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    // Inhibit flag positions inside the 64-bit configuration value
    localparam int unsigned BIT_M  = 62;
    localparam int unsigned BIT_S  = 61;
    localparam int unsigned BIT_U  = 60;
    localparam int unsigned BIT_VS = 59;
    localparam int unsigned BIT_VU = 58;

    localparam logic [63:0] INH_MASK = (64'd1 << BIT_M) | (64'd1 << BIT_S) |
                                       (64'd1 << BIT_U) | (64'd1 << BIT_VS) |
                                       (64'd1 << BIT_VU);

    typedef struct packed {
        logic m;
        logic s;
        logic u;
        logic vs;
        logic vu;
    } inh_t;

endpackage

// File: rtl/pfc_mode_track.sv
// Captures the mode presented by the core at each edge.
// Assumes priv_i/virt_i describe the mode that follows the current cycle,
// so the registered copy is the mode that ran the current step.
module pfc_mode_track
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    output priv_e      mode_priv_o,
    output logic       mode_virt_o
);

    priv_e mode_priv_q;
    logic  mode_virt_q;

    // Hold the mode one cycle so a same-cycle change is not charged to the step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_priv_q <= PRIV_M;
            mode_virt_q <= 1'b0;
        end else begin
            mode_priv_q <= priv_e'(priv_i);
            mode_virt_q <= virt_i;
        end
    end

    assign mode_priv_o = mode_priv_q;
    assign mode_virt_o = mode_virt_q;

endmodule

// File: rtl/pfc_inhibit_sel.sv
// Picks the inhibit flag that applies to the mode that ran the step.
// Assumes the reserved privilege value behaves as machine mode.
module pfc_inhibit_sel
    import pfc_pkg::*;
(
    input  inh_t  inh_i,
    input  priv_e priv_i,
    input  logic  virt_i,
    output logic  inhibit_o
);

    // Mode-to-flag selection; virtualization matters only below machine mode
    always_comb begin
        unique case (priv_i)
            PRIV_U:  inhibit_o = virt_i ? inh_i.vu : inh_i.u;
            PRIV_S:  inhibit_o = virt_i ? inh_i.vs : inh_i.s;
            default: inhibit_o = inh_i.m;
        endcase
    end

endmodule

// File: rtl/pfc_cfg_reg.sv
// Configuration register holding the five inhibit flags.
// Assumes XLEN is 32 (two halves) or 64 (single access). With FILTER_EN = 0
// nothing is writable and the value stays zero.
module pfc_cfg_reg
    import pfc_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter bit          FILTER_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic            hi_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [63:0]     cfg_o
);

    localparam logic [63:0] WMASK = FILTER_EN ? INH_MASK : 64'd0;

    logic [63:0] cfg_q;
    logic [63:0] merged;

    generate
        if (XLEN == 32) begin : g_split
            // Merge the written half with the untouched half
            always_comb begin
                merged = hi_i ? {wdata_i[31:0], cfg_q[31:0]}
                              : {cfg_q[63:32], wdata_i[31:0]};
            end
        end else begin : g_full
            // Whole-register write; the half select plays no part
            always_comb begin
                merged = 64'(wdata_i) | (64'(hi_i) & 64'd0);
            end
        end
    endgenerate

    // Store only the writable flags
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= 64'd0;
        else if (we_i) cfg_q <= merged & WMASK;
    end

    assign cfg_o = cfg_q;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q));

    // R2
    cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cfg_q & ~INH_MASK) == 64'd0);

endmodule

// File: rtl/pfc_counter.sv
// 64-bit counter with software write, split into halves when XLEN is 32.
// Assumes the caller has already applied the inhibit gate to add_en_i.
module pfc_counter #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic             we_i,
    input  logic             hi_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [63:0]      count_o
);

    logic [63:0] count_q;
    logic [63:0] written;
    logic [63:0] nxt;

    generate
        if (XLEN == 32) begin : g_split
            // Replace the selected half only
            always_comb begin
                written = hi_i ? {wdata_i[31:0], count_q[31:0]}
                               : {count_q[63:32], wdata_i[31:0]};
            end

            // R9
            wr_lo_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && !hi_i) |=> count_q[31:0] == $past(wdata_i[31:0]));

            // R10
            wr_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && !hi_i) |=> count_q[63:32] == $past(count_q[63:32]));

            // R10
            wr_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && hi_i) |=> count_q[31:0] == $past(count_q[31:0]));
        end else begin : g_full
            // Whole-register replacement
            always_comb begin
                written = 64'(wdata_i) | (64'(hi_i) & 64'd0);
            end

            // R9
            wr_full_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                we_i |=> count_q == 64'($past(wdata_i)));
        end
    endgenerate

    // Software write wins over the increment
    always_comb begin
        if (we_i)          nxt = written;
        else if (add_en_i) nxt = count_q + 64'(inc_i);
        else               nxt = count_q;
    end

    // Counter state
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= 64'd0;
        else        count_q <= nxt;
    end

    assign count_o = count_q;

endmodule

// File: rtl/priv_filter_counter.sv
// Top of the privilege-filtered event counter. Gates each step by the
// inhibit flag of the mode that ran it, using the configuration value from
// before any same-cycle write. Provides a CSR read mux over counter/config.
// Assumes XLEN is 32 or 64.
module priv_filter_counter
    import pfc_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned INC_W     = 8,
    parameter bit          FILTER_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [1:0]       priv_i,
    input  logic             virt_i,
    input  logic             csr_we_i,
    input  logic             csr_sel_i,
    input  logic             csr_hi_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    output logic [63:0]      count_o,
    output logic [63:0]      cfg_o
);

    initial begin
        xlen_legal_chk: assert (XLEN == 32 || XLEN == 64);
    end

    logic  cnt_we;
    logic  cfg_we;
    logic  inhibit;
    logic  add_en;
    priv_e mode_priv;
    logic  mode_virt;
    inh_t  inh;

    assign cnt_we = csr_we_i && !csr_sel_i;
    assign cfg_we = csr_we_i &&  csr_sel_i;

    pfc_mode_track i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_i      (priv_i),
        .virt_i      (virt_i),
        .mode_priv_o (mode_priv),
        .mode_virt_o (mode_virt)
    );

    pfc_cfg_reg #(.XLEN(XLEN), .FILTER_EN(FILTER_EN)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .hi_i    (csr_hi_i),
        .wdata_i (csr_wdata_i),
        .cfg_o   (cfg_o)
    );

    // Pull the flags out of the stored (pre-write) configuration
    always_comb begin
        inh.m  = cfg_o[BIT_M];
        inh.s  = cfg_o[BIT_S];
        inh.u  = cfg_o[BIT_U];
        inh.vs = cfg_o[BIT_VS];
        inh.vu = cfg_o[BIT_VU];
    end

    pfc_inhibit_sel i_sel (
        .inh_i     (inh),
        .priv_i    (mode_priv),
        .virt_i    (mode_virt),
        .inhibit_o (inhibit)
    );

    assign add_en = step_i && !inhibit;

    pfc_counter #(.XLEN(XLEN), .INC_W(INC_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en_i (add_en),
        .inc_i    (inc_i),
        .we_i     (cnt_we),
        .hi_i     (csr_hi_i),
        .wdata_i  (csr_wdata_i),
        .count_o  (count_o)
    );

    generate
        if (XLEN == 32) begin : g_rd_split
            // Select the register, then the half
            always_comb begin
                if (csr_sel_i) csr_rdata_o = csr_hi_i ? cfg_o[63:32]   : cfg_o[31:0];
                else           csr_rdata_o = csr_hi_i ? count_o[63:32] : count_o[31:0];
            end
        end else begin : g_rd_full
            // Select the whole register
            always_comb begin
                csr_rdata_o = csr_sel_i ? XLEN'(cfg_o) : XLEN'(count_o);
            end
        end
    endgenerate

    // R6
    count_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !inhibit && !cnt_we) |=> count_o == $past(count_o) + 64'($past(inc_i)));

    // R3
    inhibit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && inhibit && !cnt_we) |=> $stable(count_o));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !csr_we_i) |=> ($stable(count_o) && $stable(cfg_o)));

endmodule

// File: tb/test_priv_filter_counter.sv
`timescale 1ns/1ps
module test_priv_filter_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [7:0]  inc = '0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic        hi = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_nf;
    logic [63:0] count, cfg, count_nf, cfg_nf;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_cnt = '0;
    bit done = 0;

    always #4 clk = ~clk;

    priv_filter_counter #(.XLEN(32), .INC_W(8), .FILTER_EN(1'b1)) i_priv_filter_counter (
        .clk(clk), .rst_n(rst_n), .step_i(step), .inc_i(inc), .priv_i(priv), .virt_i(virt),
        .csr_we_i(we), .csr_sel_i(sel), .csr_hi_i(hi), .csr_wdata_i(wdata),
        .csr_rdata_o(rdata), .count_o(count), .cfg_o(cfg));

    priv_filter_counter #(.XLEN(32), .INC_W(8), .FILTER_EN(1'b0)) i_priv_filter_counter_nf (
        .clk(clk), .rst_n(rst_n), .step_i(step), .inc_i(inc), .priv_i(priv), .virt_i(virt),
        .csr_we_i(we), .csr_sel_i(sel), .csr_hi_i(hi), .csr_wdata_i(wdata),
        .csr_rdata_o(rdata_nf), .count_o(count_nf), .cfg_o(cfg_nf));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge and released after
    task automatic cyc(input logic s, input logic [7:0] a, input logic [1:0] p, input logic v,
                       input logic w, input logic sl, input logic h, input logic [31:0] d);
        step = s; inc = a; priv = p; virt = v; we = w; sel = sl; hi = h; wdata = d;
        @(negedge clk);
        step = 1'b0; we = 1'b0;
    endtask

    task automatic set_cfg_hi(input logic [31:0] d);
        cyc(1'b0, 8'd0, priv, virt, 1'b1, 1'b1, 1'b1, d);
    endtask

    task automatic rd(input logic sl, input logic h, output logic [31:0] d);
        sel = sl; hi = h; #1; d = rdata;
    endtask

    function automatic int sel_bit(input logic [1:0] p, input logic v);
        if (p == 2'd0)      return v ? 58 : 60;
        else if (p == 2'd1) return v ? 59 : 61;
        else                return 62;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1 count", count, 64'd0);
        check("R1 cfg", cfg, 64'd0);
        rd(1'b0, 1'b1, d); check("R12 read count hi", 64'(d), 64'd0);
        // Machine mode after reset counts
        cyc(1'b1, 8'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        exp_cnt += 2; check("R1 counts after reset", count, exp_cnt);
    endtask

    task automatic t_cfg_mask();
        logic [31:0] d;
        set_cfg_hi(32'hFFFF_FFFF);
        rd(1'b1, 1'b1, d); check("R2 cfg hi writable bits", 64'(d), 64'h7C00_0000);
        cyc(1'b0, 8'd0, priv, virt, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
        rd(1'b1, 1'b0, d); check("R2 cfg lo reads zero", 64'(d), 64'd0);
        check("R12 cfg port", cfg, 64'h7C00_0000_0000_0000);
        set_cfg_hi(32'd0);
    endtask

    task automatic t_modes();
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 2; v++) begin
                for (int b = 58; b <= 62; b++) begin
                    set_cfg_hi(32'd1 << (b - 32));
                    cyc(1'b0, 8'd0, 2'(p), 1'(v), 1'b0, 1'b0, 1'b0, 32'd0);
                    cyc(1'b1, 8'd5, 2'(p), 1'(v), 1'b0, 1'b0, 1'b0, 32'd0);
                    if (b != sel_bit(2'(p), 1'(v))) exp_cnt += 5;
                    // R3 R4 R5 R6
                    check($sformatf("R3/R4/R5 priv %0d virt %0d bit %0d", p, v, b), count, exp_cnt);
                end
            end
        end
        set_cfg_hi(32'd0);
    endtask

    task automatic t_mode_lag();
        set_cfg_hi(32'd1 << 30);                                   // inhibit machine
        cyc(1'b0, 8'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        cyc(1'b1, 8'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);      // still charged to M
        check("R7 change charged to old mode", count, exp_cnt);
        cyc(1'b1, 8'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        exp_cnt += 7; check("R7 new mode next step", count, exp_cnt);
        set_cfg_hi(32'd1 << 28);                                   // inhibit user
        cyc(1'b1, 8'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);      // charged to U
        check("R7 leave user same cycle", count, exp_cnt);
        cyc(1'b1, 8'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        exp_cnt += 4; check("R7 machine after", count, exp_cnt);
        set_cfg_hi(32'd0);
    endtask

    task automatic t_cfg_same_step();
        cyc(1'b0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        cyc(1'b1, 8'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'd1 << 28);
        exp_cnt += 3; check("R8 set inhibit same step still counts", count, exp_cnt);
        check("R8 cfg updated", cfg, 64'd1 << 60);
        cyc(1'b1, 8'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        check("R8 next step inhibited", count, exp_cnt);
        cyc(1'b1, 8'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'd0);
        check("R8 clear inhibit same step not counted", count, exp_cnt);
        cyc(1'b1, 8'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        exp_cnt += 2; check("R8 counted after clear", count, exp_cnt);
    endtask

    task automatic t_write_wins();
        cyc(1'b1, 8'd9, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1234_5678);
        exp_cnt = {exp_cnt[63:32], 32'h1234_5678};
        check("R9 write beats step", count, exp_cnt);
        cyc(1'b1, 8'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        exp_cnt += 1; check("R9 counting resumes", count, exp_cnt);
    endtask

    task automatic t_halves();
        logic [31:0] d;
        cyc(1'b0, 8'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFE);
        cyc(1'b0, 8'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0001);
        check("R10 halves written", count, 64'h0000_0001_FFFF_FFFE);
        cyc(1'b1, 8'd5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
        check("R10 carry into high half", count, 64'h0000_0002_0000_0003);
        cyc(1'b0, 8'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'hABCD_0000);
        rd(1'b0, 1'b0, d); check("R10 low kept on high write", 64'(d), 64'h3);
        rd(1'b0, 1'b1, d); check("R12 read count high", 64'(d), 64'hABCD_0000);
        exp_cnt = 64'hABCD_0000_0000_0003;
    endtask

    task automatic t_nofilter();
        logic [63:0] base;
        set_cfg_hi(32'hFFFF_FFFF);
        check("R11 cfg stays zero", cfg_nf, 64'd0);
        sel = 1'b1; hi = 1'b1; #1;
        check("R11 cfg read zero", 64'(rdata_nf), 64'd0);
        base = count_nf;
        cyc(1'b0, 8'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);
        cyc(1'b1, 8'd6, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);
        check("R11 never inhibited", count_nf, base + 64'd6);
        check("R3 main instance inhibited meanwhile", count, exp_cnt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_mask();
        t_modes();
        t_mode_lag();
        t_cfg_same_step();
        t_write_wins();
        t_halves();
        t_nofilter();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule